// File: doc/BRIEF.md
# E1 Transmit Frame Synthesizer

This block sits on the transmit side of an E1 line interface. It takes one bit of a 2048 kbit/s, 32-slot serial stream per clock. It puts out the same stream one clock later, with timeslot 0 rebuilt by the block and any masked timeslot replaced by an idle byte. Software picks one of two framing formats. The plain format alternates between an alignment frame and a service frame. The multiframe format groups 16 frames into two sub-multiframes of eight. Each sub-multiframe is protected by a 4-bit cyclic check, and the service frames also carry multiframe pattern bits and two error-report bits.

A strobe that is high with the first bit of a frame pins the position counters to the start of a frame. Without the strobe, the counters run freely at 256 bits per frame. The frame counter always counts modulo 16. The error-report bits can come from static inputs. They can also follow, frame by frame, the check results that a receiver reports for each of its sub-multiframes. Three pass-through options let upstream logic supply timeslot 0 itself: the whole slot, only its first bit, or only the spare bits of the service frames.

Top module: `e1tx_framer`

## Requirements
- R1: In every even frame (frame count bit 0 = 0), bits 2 to 8 of timeslot 0 are sent as 0,0,1,1,0,1,1. This holds unless timeslot 0 is masked for idle or the whole-slot pass-through is selected. Bit 1 of a slot is sent first.
- R2: In every odd frame, bit 2 of timeslot 0 is 1 and bits 4 to 8 are 1. With `crc_mode` = 0, bit 1 of timeslot 0 is 1 in every frame.
- R3: In every odd frame, bit 3 of timeslot 0 equals `rai` as sampled with that bit.
- R4: With `crc_mode` = 1, bit 1 of frames 0, 2, 4 and 6 carries C1..C4 (frames 8, 10, 12 and 14 likewise). C1..C4 is the remainder, MSB first, of the previous eight-frame sub-multiframe's transmitted bits, multiplied by x^4 and divided by x^4+x+1. The C positions count as 0 in that division. The first sub-multiframe after reset carries 0000.
- R5: With `crc_mode` = 1, bit 1 of frames 1, 3, 5, 7, 9 and 11 carries 0,0,1,0,1,1 in that order.
- R6: With `crc_mode` = 1 and `auto_e` = 0, bit 1 of frame 13 is `e_bits[0]` and bit 1 of frame 15 is `e_bits[1]`.
- R7: With `crc_mode` = 1 and `auto_e` = 1, bit 1 of frame 13 is the inverse of `rx_err[0]` and bit 1 of frame 15 is the inverse of `rx_err[1]`. A 1 on `rx_err` marks a failed receive check, which is sent as 0.
- R8: Pass-through code `tsp_mode` = 1 sends all of timeslot 0 from `din`. Code 2 sends only bit 1 of timeslot 0 from `din`, in every frame. Code 3 sends only bits 4 to 8 of the odd frames' timeslot 0 from `din`. Code 0 synthesizes the whole of timeslot 0.
- R9: When `idle_mask[n]` = 1, every bit of timeslot n is taken from `idle_byte`, bit 7 first. This applies to timeslot 0 as well, and it overrides all other sources.
- R10: Bits of timeslots 1 to 31 that are not masked leave on `dout` one clock after they arrive on `din`. `fstart` high marks the current bit as bit 1 of timeslot 0 of the next frame. Otherwise a frame is 256 bits long. The first bit after reset is frame 0, bit 1 of timeslot 0.
- R11: While `rst_n` is low, `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fstart | input | 1 | High with the first bit of a frame |
| din | input | 1 | Serial input data |
| crc_mode | input | 1 | 0 = plain double-frame, 1 = 16-frame check multiframe |
| rai | input | 1 | Remote alarm value for odd frames |
| auto_e | input | 1 | 1 = error-report bits follow `rx_err` |
| rx_err | input | 2 | Receive check failure per sub-multiframe |
| e_bits | input | 2 | Static error-report bit values |
| tsp_mode | input | 2 | Timeslot 0 pass-through selection |
| idle_byte | input | 8 | Idle pattern byte |
| idle_mask | input | 32 | Per-timeslot idle enable |
| dout | output | 1 | Serial output data, one clock behind `din` |

## Verification
If the bit or frame counters slip, the error appears within one frame. The alignment pattern lands on the wrong bits, the payload of the affected slot leaves at the wrong place, and the wrong slot receives idle bytes. A corrupted running check register or held remainder is invisible until the next sub-multiframe boundary. There, up to four wrong C bits appear in the following eight frames. Sub-multiframes of random data therefore have to be run back to back, and a resync in the middle of a frame has to be included. A bad multiframe or error-bit selection shows up only in bit 1 of the odd frames.

// File: rtl/e1tx_pkg.sv
package e1tx_pkg;
  localparam int SLOTS     = 32;
  localparam int SLOT_BITS = 8;
  localparam int FRAMES    = 16;
  localparam int POS_W     = $clog2(SLOTS * SLOT_BITS);
  localparam int FRM_W     = $clog2(FRAMES);
  localparam int TS_W      = $clog2(SLOTS);
  localparam int BIT_W     = $clog2(SLOT_BITS);

  typedef logic [POS_W-1:0] pos_t;
  typedef logic [FRM_W-1:0] frm_t;
  typedef logic [BIT_W-1:0] bit_t;

  typedef enum logic [1:0] {
    TSP_NONE  = 2'd0,
    TSP_ALL   = 2'd1,
    TSP_SI    = 2'd2,
    TSP_SPARE = 2'd3
  } tsp_e;

  // one shift of the x^4+x+1 check register
  function automatic logic [3:0] crc4_step(logic [3:0] c, logic b);
    logic fb;
    fb = c[3] ^ b;
    return {c[2:0], 1'b0} ^ {2'b00, fb, fb};
  endfunction

  // synthesized timeslot 0 bit for bit index b of frame f
  function automatic logic ts0_bit(bit_t b, frm_t f, logic crc_on, logic rai,
                                   logic [1:0] e, logic [3:0] crc);
    logic [7:0] align;
    logic [7:0] mfa;
    align = 8'b0001_1011;
    mfa   = 8'b0000_1011;
    if (!f[0]) begin
      if (b == '0) return crc_on ? crc[2'd3 - f[2:1]] : 1'b1;
      return align[3'd7 - b];
    end
    if (b == '0) begin
      if (!crc_on) return 1'b1;
      if (f == 4'd13) return e[0];
      if (f == 4'd15) return e[1];
      return mfa[3'd5 - f[3:1]];
    end
    if (b == 3'd2) return rai;
    return 1'b1;
  endfunction
endpackage

// File: rtl/e1tx_count.sv
module e1tx_count
  import e1tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fstart,
  output pos_t pos,
  output frm_t frm
);
  localparam pos_t LAST = pos_t'(SLOTS * SLOT_BITS - 1);

  pos_t pos_q;
  frm_t frm_q;
  logic wrap;

  assign wrap = fstart || (pos_q == LAST);
  assign pos  = wrap ? '0 : pos_q + 1'b1;
  assign frm  = wrap ? frm_q + 1'b1 : frm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= LAST;
      frm_q <= '1;
    end else begin
      pos_q <= pos;
      frm_q <= frm;
    end
  end

  // R10
  pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos != '0) |-> (pos == $past(pos) + 1'b1));

  // R10
  frm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos != '0) |-> (frm == $past(frm)));
endmodule

// File: rtl/e1tx_crc.sv
module e1tx_crc
  import e1tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smf_start,
  input  logic       bit_in,
  output logic [3:0] crc_now
);
  logic [3:0] run_q;
  logic [3:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= '0;
      hold_q <= '0;
    end else if (smf_start) begin
      hold_q <= run_q;
      run_q  <= crc4_step(4'd0, bit_in);
    end else begin
      run_q  <= crc4_step(run_q, bit_in);
    end
  end

  // the sub-multiframe just closed is usable in its own start cycle
  assign crc_now = smf_start ? run_q : hold_q;

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smf_start |=> $stable(hold_q));
endmodule

// File: rtl/e1tx_framer.sv
module e1tx_framer
  import e1tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fstart,
  input  logic              din,
  input  logic              crc_mode,
  input  logic              rai,
  input  logic              auto_e,
  input  logic [1:0]        rx_err,
  input  logic [1:0]        e_bits,
  input  logic [1:0]        tsp_mode,
  input  logic [SLOT_BITS-1:0] idle_byte,
  input  logic [SLOTS-1:0]  idle_mask,
  output logic              dout
);
  localparam logic [7:0] ALIGN_REF = 8'b0001_1011;

  pos_t              pos;
  frm_t              frm;
  logic [TS_W-1:0]   ts;
  bit_t              b;
  logic              smf_start;
  logic              crc_slot;
  logic [3:0]        crc_now;
  logic [1:0]        e_sel;
  logic              synth;
  logic              out_c;
  logic              crc_in;
  logic              dout_q;

  e1tx_count u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .fstart (fstart),
    .pos    (pos),
    .frm    (frm)
  );

  assign ts        = pos[POS_W-1:BIT_W];
  assign b         = pos[BIT_W-1:0];
  assign smf_start = (pos == '0) && (frm[FRM_W-2:0] == '0);
  assign crc_slot  = crc_mode && (ts == '0) && (b == '0) && !frm[0];
  assign e_sel     = auto_e ? ~rx_err : e_bits;
  assign synth     = ts0_bit(b, frm, crc_mode, rai, e_sel, crc_now);

  always_comb begin
    out_c = din;
    if (idle_mask[ts]) begin
      out_c = idle_byte[3'd7 - b];
    end else if (ts == '0) begin
      unique case (tsp_e'(tsp_mode))
        TSP_ALL:   out_c = din;
        TSP_SI:    out_c = (b == '0) ? din : synth;
        TSP_SPARE: out_c = (frm[0] && b >= 3'd3) ? din : synth;
        default:   out_c = synth;
      endcase
    end
  end

  assign crc_in = crc_slot ? 1'b0 : out_c;

  e1tx_crc u_crc (
    .clk       (clk),
    .rst_n     (rst_n),
    .smf_start (smf_start),
    .bit_in    (crc_in),
    .crc_now   (crc_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) dout_q <= 1'b0;
    else        dout_q <= out_c;
  end
  assign dout = dout_q;

  // named events for the checks
  logic ts0_own;
  logic fas_slot;
  logic fas_exp;
  logic rai_slot;
  logic idle_hit;
  logic idle_bit;
  logic pass_slot;
  assign ts0_own   = (ts == '0) && !idle_mask[0] && (tsp_mode != TSP_ALL);
  assign fas_slot  = ts0_own && !frm[0] && (b != '0);
  assign fas_exp   = ALIGN_REF[3'd7 - b];
  assign rai_slot  = ts0_own && frm[0] && (b == 3'd2);
  assign idle_hit  = idle_mask[ts];
  assign idle_bit  = idle_byte[3'd7 - b];
  assign pass_slot = (ts != '0) && !idle_mask[ts];

  // R1
  fas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fas_slot |=> (dout == $past(fas_exp)));

  // R3
  rai_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rai_slot |=> (dout == $past(rai)));

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_hit |=> (dout == $past(idle_bit)));

  // R10
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_slot |=> (dout == $past(din)));

  // R11
  always_ff @(posedge clk) begin
    if (!rst_n) reset_out_chk: assert (dout_q == 1'b0 || $past(rst_n));
  end
endmodule

// File: tb/sim_e1tx_framer.sv
`timescale 1ns/1ps
module sim_e1tx_framer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fstart = 1'b0;
  logic        din = 1'b0;
  logic        crc_mode = 1'b0;
  logic        rai = 1'b0;
  logic        auto_e = 1'b0;
  logic [1:0]  rx_err = '0;
  logic [1:0]  e_bits = '0;
  logic [1:0]  tsp_mode = '0;
  logic [7:0]  idle_byte = '0;
  logic [31:0] idle_mask = '0;
  logic        dout;

  int total = 0;
  int bad = 0;
  logic churn = 1'b0;

  logic [7:0] m_pos = 8'd255;
  logic [3:0] m_frm = 4'd15;
  logic [3:0] m_rem = 4'd0;
  logic       sq[$];

  always #2.5 clk = ~clk;

  e1tx_framer u0 (
    .clk(clk), .rst_n(rst_n), .fstart(fstart), .din(din), .crc_mode(crc_mode),
    .rai(rai), .auto_e(auto_e), .rx_err(rx_err), .e_bits(e_bits),
    .tsp_mode(tsp_mode), .idle_byte(idle_byte), .idle_mask(idle_mask),
    .dout(dout)
  );

  // long division of the stored bits times x^4 by 10011
  function automatic logic [3:0] div_rem();
    logic [4:0] r;
    r = '0;
    for (int i = 0; i < sq.size() + 4; i++) begin
      r = {r[3:0], (i < sq.size()) ? sq[i] : 1'b0};
      if (r[4]) r = r ^ 5'b10011;
    end
    return r[3:0];
  endfunction

  function automatic logic [7:0] ts0_byte(logic [3:0] f, logic cm, logic r,
                                          logic e1, logic e2, logic [3:0] rem);
    logic si;
    if (!cm)           si = 1'b1;
    else if (!f[0])    si = rem[3 - f[2:1]];
    else if (f == 13)  si = e1;
    else if (f == 15)  si = e2;
    else               si = (f == 5) || (f == 9) || (f == 11);
    return f[0] ? {si, 1'b1, r, 5'b11111} : {si, 7'b0011011};
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b frame=%0d pos=%0d",
               tag, act, exp, m_frm, m_pos);
    end
  endtask

  task automatic step(input logic fs);
    logic [4:0] ts;
    logic [2:0] b;
    logic ex;
    logic e1, e2;
    string tg;
    fstart = fs;
    din = 1'($urandom);
    if (churn) begin
      rai = 1'($urandom);
      rx_err = 2'($urandom);
      e_bits = 2'($urandom);
    end
    if (fs || m_pos == 8'd255) begin
      m_pos = 8'd0;
      m_frm = m_frm + 4'd1;
    end else begin
      m_pos = m_pos + 8'd1;
    end
    if (m_pos == 0 && m_frm[2:0] == 0) begin
      m_rem = div_rem();
      sq.delete();
    end
    ts = m_pos[7:3];
    b  = m_pos[2:0];
    e1 = auto_e ? ~rx_err[0] : e_bits[0];
    e2 = auto_e ? ~rx_err[1] : e_bits[1];
    if (idle_mask[ts]) begin
      ex = idle_byte[7 - b]; tg = "R9";
    end else if (ts != 0) begin
      ex = din; tg = "R10";
    end else if (tsp_mode == 2'd1 || (tsp_mode == 2'd2 && b == 0) ||
                 (tsp_mode == 2'd3 && m_frm[0] && b >= 3)) begin
      ex = din; tg = "R8";
    end else begin
      ex = ts0_byte(m_frm, crc_mode, rai, e1, e2, m_rem)[7 - b];
      if (!m_frm[0])      tg = (b != 0) ? "R1" : (crc_mode ? "R4" : "R2");
      else if (b == 2)    tg = "R3";
      else if (b != 0)    tg = "R2";
      else if (!crc_mode) tg = "R2";
      else if (m_frm == 13 || m_frm == 15) tg = auto_e ? "R7" : "R6";
      else                tg = "R5";
    end
    sq.push_back((crc_mode && ts == 0 && b == 0 && !m_frm[0]) ? 1'b0 : ex);
    @(negedge clk);
    chk(dout, ex, tg);
  endtask

  task automatic phase(input int nfr, input int fsm, input logic cm, input logic ae,
                       input logic [1:0] tp, input logic idl);
    crc_mode = cm;
    auto_e = ae;
    tsp_mode = tp;
    idle_byte = 8'($urandom);
    idle_mask = idl ? (($urandom & $urandom & $urandom) | 32'h1) : 32'h0;
    for (int i = 0; i < nfr * 256; i++) begin
      logic fs;
      fs = 1'b0;
      if (fsm == 1 && m_pos == 8'd255) fs = 1'b1;
      if (fsm == 2 && (i % 3001) == 1234) fs = 1'b1;
      step(fs);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    total++;
    bad++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (4) @(negedge clk);
    chk(dout, 1'b0, "R11");
    rst_n = 1'b1;
    churn = 1'b0;
    rai = 1'b1;
    phase(8, 0, 1'b0, 1'b0, 2'd0, 1'b0);    // plain format, free running
    churn = 1'b1;
    phase(48, 1, 1'b1, 1'b0, 2'd0, 1'b0);   // multiframe, aligned strobes
    phase(32, 0, 1'b1, 1'b1, 2'd0, 1'b0);   // automatic error bits
    phase(8, 1, 1'b1, 1'b0, 2'd1, 1'b0);    // whole slot pass-through
    phase(16, 0, 1'b1, 1'b0, 2'd2, 1'b0);   // first-bit pass-through
    phase(16, 0, 1'b0, 1'b0, 2'd3, 1'b0);   // spare pass-through
    phase(16, 0, 1'b1, 1'b1, 2'd0, 1'b1);   // idle slots incl. slot 0
    phase(32, 2, 1'b1, 1'b0, 2'd0, 1'b0);   // mid-frame resyncs
    phase(24, 0, 1'b1, 1'b1, 2'd0, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    din = 1'b1;
    idle_mask = '1;
    idle_byte = 8'hFF;
    @(negedge clk);
    chk(dout, 1'b0, "R11");
    @(negedge clk);
    chk(dout, 1'b0, "R11");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule